// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing information of one instruction of an 8-bit processor with a 16-bit address space into a memory address, a sequential-or-branch next program counter and the instruction's byte count. Opcode decoding, fetch sequencing and condition evaluation happen elsewhere. The sequencer presents the addressing mode, up to two operand bytes taken from after the opcode, both index registers, the address of the instruction's first byte, a flag for an escape byte ahead of the opcode, and the already evaluated branch condition. One clock later the four results appear on registered outputs.

Memory-operand modes have four forms. A page-zero form reaches only the lowest 256 bytes with a single operand byte. An absolute form takes a full 16-bit address from two bytes. Two indexed forms add an unsigned byte to one of the index registers. Register-only instructions and branches produce no memory address. A taken branch redirects the next program counter by a signed byte displacement, measured from the end of the branch instruction. Every addition wraps at 16 bits.

Top module: `opAddrGen`

## Requirements
- R1: With modeSel = 1 (page zero) the address is {0x00, opByte0}, addrValid is 1 and instLen is 2 plus hasPrebyte.
- R2: With modeSel = 2 (absolute) the address is {opByte0, opByte1}, with the first operand byte as the high half. addrValid is 1 and instLen is 3 plus hasPrebyte.
- R3: With modeSel = 3 (indexed by X) the address is idxX plus opByte0 zero-extended, modulo 65536. addrValid is 1 and instLen is 2 plus hasPrebyte.
- R4: With modeSel = 4 (indexed by Y) the address is idxY plus opByte0 zero-extended, modulo 65536. addrValid is 1 and instLen is always 3, because this form always carries the escape byte, whatever hasPrebyte says.
- R5: With modeSel = 0 (register-only), or with the unused codes 6 and 7, addrValid is 0, the address is 0x0000 and instLen is 1 plus hasPrebyte.
- R6: With modeSel = 5 (branch) addrValid is 0, the address is 0x0000 and instLen is 2 plus hasPrebyte. When branchTaken is 1, nextPc is pcIn + instLen + the sign-extended opByte0, modulo 65536. Otherwise nextPc is pcIn + instLen.
- R7: In every mode other than a taken branch, nextPc is pcIn + instLen modulo 65536.
- R8: All four outputs are registered: they change only on the rising clock edge after their inputs. A synchronous active-high rst clears addrOut, addrValid, nextPc and instLen to zero.
- R9: Inputs a mode does not use have no effect on the outputs. This covers opByte1 outside mode 2, branchTaken outside mode 5, and both index registers outside modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 3 | Addressing mode code (0 to 5, 6 and 7 unused) |
| opByte0 | input | 8 | First byte after the opcode |
| opByte1 | input | 8 | Second byte after the opcode |
| idxX | input | 16 | Index register X |
| idxY | input | 16 | Index register Y |
| pcIn | input | 16 | Address of the instruction's first byte |
| hasPrebyte | input | 1 | An escape byte precedes the opcode |
| branchTaken | input | 1 | Evaluated branch condition |
| addrOut | output | 16 | Effective address |
| addrValid | output | 1 | addrOut names a memory operand |
| nextPc | output | 16 | Program counter of the following instruction |
| instLen | output | 3 | Instruction length in bytes |

## Verification
In branch mode, the length adjustment and the signed displacement both feed the same next-PC result in one cycle. Both can also cross the 0xFFFF boundary. The bench provokes this with random branches that have the escape flag set, negative displacements such as 0x80, and pcIn placed just below the wrap point. Each result is judged against a bench function that sums length and displacement independently, modulo 65536.

// File: rtl/opag_pkg.sv
package opag_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;

  typedef enum logic [2:0] {
    MODE_INH   = 3'd0,
    MODE_DIR   = 3'd1,
    MODE_EXT   = 3'd2,
    MODE_IDX_X = 3'd3,
    MODE_IDX_Y = 3'd4,
    MODE_REL   = 3'd5
  } opagMode_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PAGE0 = 2'd1,
    SRC_ABS   = 2'd2,
    SRC_INDEX = 2'd3
  } addrSrc_e;

  typedef struct packed {
    logic             addrValid;
    addrSrc_e         addrSrc;
    logic             useIy;
    logic             isBranch;
    logic [LEN_W-1:0] instLen;
  } opagStrobe_t;
endpackage

// File: rtl/opag_ctrl.sv
module opag_ctrl
  import opag_pkg::*;
(
  input  logic [2:0]  modeSel,
  input  logic        hasPrebyte,
  output opagStrobe_t strb
);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO   = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_THREE = LEN_W'(3);

  logic [LEN_W-1:0] baseLen;
  logic             addEscape;

  always_comb begin
    strb.addrValid = 1'b0;
    strb.addrSrc   = SRC_NONE;
    strb.useIy     = 1'b0;
    strb.isBranch  = 1'b0;
    baseLen        = LEN_ONE;
    addEscape      = hasPrebyte;
    case (modeSel)
      MODE_DIR: begin
        strb.addrValid = 1'b1;
        strb.addrSrc   = SRC_PAGE0;
        baseLen        = LEN_TWO;
      end
      MODE_EXT: begin
        strb.addrValid = 1'b1;
        strb.addrSrc   = SRC_ABS;
        baseLen        = LEN_THREE;
      end
      MODE_IDX_X: begin
        strb.addrValid = 1'b1;
        strb.addrSrc   = SRC_INDEX;
        baseLen        = LEN_TWO;
      end
      MODE_IDX_Y: begin
        strb.addrValid = 1'b1;
        strb.addrSrc   = SRC_INDEX;
        strb.useIy     = 1'b1;
        baseLen        = LEN_TWO;
        addEscape      = 1'b1;   // Y form always carries the escape byte
      end
      MODE_REL: begin
        strb.isBranch  = 1'b1;
        baseLen        = LEN_TWO;
      end
      default: begin
        baseLen        = LEN_ONE;
      end
    endcase
    strb.instLen = baseLen + LEN_W'(addEscape);
  end
endmodule

// File: rtl/opag_dpath.sv
module opag_dpath
  import opag_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  opagStrobe_t      strb,
  input  logic [BW-1:0]    opByte0,
  input  logic [BW-1:0]    opByte1,
  input  logic [AW-1:0]    idxX,
  input  logic [AW-1:0]    idxY,
  input  logic [AW-1:0]    pcIn,
  input  logic             branchTaken,
  output logic [AW-1:0]    addrOut,
  output logic             addrValid,
  output logic [AW-1:0]    nextPc,
  output logic [LEN_W-1:0] instLen
);
  localparam int EXT_W = AW - BW;

  logic [AW-1:0] idxBase, idxSum, seqPc, relOff, brTarget;
  logic [AW-1:0] addrNxt, pcNxt;

  always_comb begin
    idxBase  = strb.useIy ? idxY : idxX;
    idxSum   = idxBase + {{EXT_W{1'b0}}, opByte0};
    seqPc    = pcIn + AW'(strb.instLen);
    relOff   = {{EXT_W{opByte0[BW-1]}}, opByte0};
    brTarget = seqPc + relOff;
    pcNxt    = (strb.isBranch && branchTaken) ? brTarget : seqPc;
    case (strb.addrSrc)
      SRC_PAGE0: addrNxt = {{EXT_W{1'b0}}, opByte0};
      SRC_ABS:   addrNxt = {opByte0, opByte1};
      SRC_INDEX: addrNxt = idxSum;
      default:   addrNxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
      nextPc    <= '0;
      instLen   <= '0;
    end else begin
      addrOut   <= addrNxt;
      addrValid <= strb.addrValid;
      nextPc    <= pcNxt;
      instLen   <= strb.instLen;
    end
  end

  // R7 / R6: a non-taken path lands one instruction length past pcIn
  p_seq_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (!(strb.isBranch && branchTaken)) |=> (nextPc == $past(pcIn) + AW'(instLen)));

  // R8: reset empties every output
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (addrOut == '0 && !addrValid && nextPc == '0 && instLen == '0));

  // R5 / R6: an invalid address is always reported as zero
  p_invalid_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!addrValid) |-> (addrOut == '0));
endmodule

// File: rtl/opAddrGen.sv
module opAddrGen
  import opag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  modeSel,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  input  logic [15:0] idxX,
  input  logic [15:0] idxY,
  input  logic [15:0] pcIn,
  input  logic        hasPrebyte,
  input  logic        branchTaken,
  output logic [15:0] addrOut,
  output logic        addrValid,
  output logic [15:0] nextPc,
  output logic [2:0]  instLen
);
  opagStrobe_t strb;

  opag_ctrl i_ctrl (
    .modeSel    (modeSel),
    .hasPrebyte (hasPrebyte),
    .strb       (strb)
  );

  opag_dpath #(.AW(ADDR_W), .BW(BYTE_W)) i_dpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .opByte0     (opByte0),
    .opByte1     (opByte1),
    .idxX        (idxX),
    .idxY        (idxY),
    .pcIn        (pcIn),
    .branchTaken (branchTaken),
    .addrOut     (addrOut),
    .addrValid   (addrValid),
    .nextPc      (nextPc),
    .instLen     (instLen)
  );

  // R1: page-zero form never leaves the first 256 bytes
  p_page0_high_r1: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_DIR) |=> (addrValid && addrOut[15:8] == 8'h00));

  // R2: absolute form length follows the escape flag
  p_abs_len_r2: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_EXT) |=> (instLen == 3'd3 + 3'($past(hasPrebyte))));

  // R4: Y-indexed form is always three bytes
  p_idxy_len_r4: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_IDX_Y) |=> (instLen == 3'd3 && addrValid));

  // R5: register-only form has no memory operand
  p_inh_invalid_r5: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_INH) |=> (!addrValid && addrOut == 16'h0000));
endmodule

// File: tb/test_opAddrGen.sv
module test_opAddrGen;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  modeSel;
  logic [7:0]  opByte0, opByte1;
  logic [15:0] idxX, idxY, pcIn;
  logic        hasPrebyte, branchTaken;
  logic [15:0] addrOut, nextPc;
  logic        addrValid;
  logic [2:0]  instLen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opAddrGen i_opAddrGen (
    .clk(clk), .rst(rst), .modeSel(modeSel), .opByte0(opByte0), .opByte1(opByte1),
    .idxX(idxX), .idxY(idxY), .pcIn(pcIn), .hasPrebyte(hasPrebyte),
    .branchTaken(branchTaken), .addrOut(addrOut), .addrValid(addrValid),
    .nextPc(nextPc), .instLen(instLen)
  );

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  function automatic void refModel(
    input logic [2:0] m, input logic [7:0] b0, input logic [7:0] b1,
    input logic [15:0] x, input logic [15:0] y, input logic [15:0] pc,
    input logic pre, input logic tk,
    output logic [15:0] ea, output logic v, output logic [15:0] np, output logic [2:0] len);
    int l;
    ea = 16'h0; v = 1'b0;
    case (m)
      3'd1: begin ea = {8'h00, b0}; v = 1'b1; l = 2 + int'(pre); end
      3'd2: begin ea = {b0, b1}; v = 1'b1; l = 3 + int'(pre); end
      3'd3: begin ea = 16'((int'(x) + int'(b0)) % 65536); v = 1'b1; l = 2 + int'(pre); end
      3'd4: begin ea = 16'((int'(y) + int'(b0)) % 65536); v = 1'b1; l = 3; end
      3'd5: l = 2 + int'(pre);
      default: l = 1 + int'(pre);
    endcase
    len = 3'(l);
    if (m == 3'd5 && tk)
      np = 16'((int'(pc) + l + int'($signed(b0)) + 65536) % 65536);
    else
      np = 16'((int'(pc) + l) % 65536);
  endfunction

  task automatic compare(input string tag, input logic [15:0] ea, input logic v,
                         input logic [15:0] np, input logic [2:0] len);
    checks++;
    if (addrOut !== ea || addrValid !== v || nextPc !== np || instLen !== len) begin
      errors++;
      $display("FAIL %s: got ea=%h v=%b np=%h len=%0d, expected ea=%h v=%b np=%h len=%0d",
               tag, addrOut, addrValid, nextPc, instLen, ea, v, np, len);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [15:0] x, input logic [15:0] y, input logic [15:0] pc,
                       input logic pre, input logic tk);
    modeSel = m; opByte0 = b0; opByte1 = b1; idxX = x; idxY = y;
    pcIn = pc; hasPrebyte = pre; branchTaken = tk;
  endtask

  task automatic runVec(input string tag, input logic [2:0] m, input logic [7:0] b0,
                        input logic [7:0] b1, input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] pc, input logic pre, input logic tk);
    logic [15:0] ea, np; logic v; logic [2:0] len;
    drive(m, b0, b1, x, y, pc, pre, tk);
    refModel(m, b0, b1, x, y, pc, pre, tk, ea, v, np, len);
    @(posedge clk); #1;
    compare(tag, ea, v, np, len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] eaA, npA, eaB, npB; logic vA, vB; logic [2:0] lenA, lenB;
    void'($urandom(32'h5eed_0c11));
    rst = 1'b1;
    drive(3'd2, 8'h12, 8'h34, 16'h1111, 16'h2222, 16'h4000, 1'b1, 1'b1);
    repeat (2) @(posedge clk); #1;
    compare("R8 reset", 16'h0, 1'b0, 16'h0, 3'd0);
    rst = 1'b0;

    // R8: outputs hold until the next edge
    drive(3'd1, 8'h5a, 8'h00, 16'h0, 16'h0, 16'h0100, 1'b0, 1'b0);
    #1 compare("R8 latency", 16'h0, 1'b0, 16'h0, 3'd0);
    @(posedge clk); #1;
    compare("R1 page0", 16'h005a, 1'b1, 16'h0102, 3'd2);

    runVec("R1 page0 prebyte", 3'd1, 8'hff, 8'hee, 16'h0, 16'h0, 16'h2000, 1'b1, 1'b0);
    runVec("R2 absolute", 3'd2, 8'hbe, 8'hef, 16'h0, 16'h0, 16'h3000, 1'b0, 1'b0);
    runVec("R3 idx wrap", 3'd3, 8'hff, 8'h00, 16'hffff, 16'h0, 16'h1234, 1'b0, 1'b0);
    runVec("R4 idxY ignores flag", 3'd4, 8'h10, 8'h00, 16'h0, 16'hfff8, 16'h1000, 1'b0, 1'b0);
    runVec("R5 inherent", 3'd0, 8'h77, 8'h88, 16'h1, 16'h2, 16'h5000, 1'b1, 1'b1);
    runVec("R5 unused code", 3'd7, 8'h77, 8'h88, 16'h1, 16'h2, 16'h5000, 1'b0, 1'b0);
    runVec("R6 neg offset", 3'd5, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0010, 1'b1, 1'b1);
    runVec("R6 wrap forward", 3'd5, 8'h7f, 8'h00, 16'h0, 16'h0, 16'hfff0, 1'b0, 1'b1);
    runVec("R6 not taken", 3'd5, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0010, 1'b0, 1'b0);
    runVec("R7 seq wrap", 3'd2, 8'h00, 8'h01, 16'h0, 16'h0, 16'hfffe, 1'b1, 1'b0);

    // R9: unused inputs changed, results must be identical
    refModel(3'd1, 8'h44, 8'h00, 16'h0, 16'h0, 16'h0200, 1'b0, 1'b0, eaA, vA, npA, lenA);
    drive(3'd1, 8'h44, 8'hc3, 16'habcd, 16'h1357, 16'h0200, 1'b0, 1'b1);
    @(posedge clk); #1;
    compare("R9 page0 unused inputs", eaA, vA, npA, lenA);
    refModel(3'd3, 8'h20, 8'h00, 16'h0100, 16'h0, 16'h0300, 1'b0, 1'b0, eaB, vB, npB, lenB);
    drive(3'd3, 8'h20, 8'h99, 16'h0100, 16'hffff, 16'h0300, 1'b0, 1'b1);
    @(posedge clk); #1;
    compare("R9 idxX unused inputs", eaB, vB, npB, lenB);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m;
      logic [15:0] pc;
      m  = 3'($urandom_range(0, 7));
      pc = (i % 5 == 0) ? 16'($urandom_range(16'hfff0, 16'hffff)) : 16'($urandom);
      runVec(tagOf(m), m, 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
             pc, 1'($urandom), 1'($urandom));
    end

    rst = 1'b1;
    @(posedge clk); #1;
    compare("R8 mid-run reset", 16'h0, 1'b0, 16'h0, 3'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule